// File: doc/BRIEF.md
# Sequenced Register-Transfer Data Mover

This block takes a small input word and produces an output word through a fixed program of register transfers. A built-in step controller runs that program. The datapath has three working registers, `a`, `b` and `c`, plus an output register `z`. All of them are as wide as the input bus. Each accepted start request runs five steps in order:

1. Load `a` from the input.
2. Write the bitwise complement of `a` into `c`.
3. Write `c` into `b` with its bit order reversed.
4. Write the bitwise OR of `a` and `b` into `c`.
5. Copy `c` into the output register.

The net result is `z = x | reverse(~x)`.

The controller gives every step a two-cycle slot: a setup phase followed by a commit phase. The register transfer happens only in the commit phase. This is a single-clock model of a controller that works on both clock edges, and it gives each transfer a fixed clock phase. A caller pulses `start` while the block is idle and holds `x` through the load step. It then waits for the one-cycle `done` pulse and reads `z`, which keeps its value until the next run completes. The width is a parameter: 2 bits is the base case and 4 bits is the scaled case.

Top module: `seq_xfer_mover`

## Requirements
- R1: With W=2, each completed run leaves `z` equal to `x | reverse(~x)` for all four input values. Bit i of `reverse(v)` is bit W-1-i of `v`.
- R2: With W=4, the same relation holds for all sixteen input values.
- R3: The five transfers (load, complement, reverse, merge, output) run in that order. Only one transfer happens per clock. Consecutive transfers are exactly two cycles apart, because each step has a setup phase and a commit phase.
- R4: `done` goes high exactly 10 cycles after the clock edge that accepts `start`, and `z` carries the new result in that same cycle.
- R5: `start` is accepted only while `busy` is low. A `start` that arrives during a run does not restart it and does not move its completion time, and no second run follows.
- R6: `z` keeps its value between completions, whatever `x` and `start` do in between.
- R7: `busy` rises on the edge that accepts `start` and falls on the edge where `done` rises. `done` stays high for exactly one cycle.
- R8: A synchronous active-high reset clears `z`, `busy` and `done` and returns the controller to idle, including when a run is in progress.
- R9: `x` is sampled only at the load step, two cycles after acceptance. Later changes to `x` do not affect that run's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a run; accepted only when idle |
| x | input | W | Input word, sampled at the load step |
| z | output | W | Registered result of the last completed run |
| busy | output | 1 | High from acceptance until completion |
| done | output | 1 | One-cycle pulse when a result is written to `z` |

## Verification
The bench sweeps every input value at both widths. It compares `z` with `x | reverse(~x)`, computed by its own bit loop. This catches a reversal that is dropped or mirrored, and a complement placed on the wrong register. Those faults do not all show at 2 bits, so the 4-bit sweep matters.

The bench counts cycles from acceptance to `done`. A sequencer that skips the setup phase, or that adds or drops a step, completes at the wrong cycle and fails this count.

Further runs check the following:
- A second `start` pulse together with a new `x` arrives mid-run. A design that restarts on it, or that samples `x` late, completes at a different time or returns the result for the later value.
- A reset lands in the middle of a run. A design that does not clear its controller would leave `busy` set or produce a stray `done`.
- Idle stretches are held while `x` changes, to catch an output register that follows its input.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_INV   = 3'd2,
    ST_REV   = 3'd3,
    ST_MERGE = 3'd4,
    ST_OUT   = 3'd5
  } step_e;

  typedef struct packed {
    logic out_z;
    logic or_c;
    logic rev_b;
    logic inv_c;
    logic ld_a;
  } xfer_stb_t;

  localparam int unsigned STB_W = 5;

  function automatic step_e next_step(input step_e s);
    case (s)
      ST_LOAD:  next_step = ST_INV;
      ST_INV:   next_step = ST_REV;
      ST_REV:   next_step = ST_MERGE;
      ST_MERGE: next_step = ST_OUT;
      default:  next_step = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/xfer_bitrev.sv
module xfer_bitrev #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_swap
    assign dout[i] = din[W-1-i];
  end

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output xfer_stb_t stb,
  output logic      busy,
  output logic      done
);

  step_e step_q;
  logic  phase_q;
  logic  busy_q;
  logic  done_q;
  logic  commit;

  // A step commits only in its second phase.
  assign commit = phase_q && (step_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= ST_IDLE;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_q == ST_IDLE) begin
        phase_q <= 1'b0;
        if (start) begin
          step_q <= ST_LOAD;
          busy_q <= 1'b1;
        end
      end else if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        step_q  <= next_step(step_q);
        if (step_q == ST_OUT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb       = '0;
    stb.ld_a  = commit && (step_q == ST_LOAD);
    stb.inv_c = commit && (step_q == ST_INV);
    stb.rev_b = commit && (step_q == ST_REV);
    stb.or_c  = commit && (step_q == ST_MERGE);
    stb.out_z = commit && (step_q == ST_OUT);
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  xfer_stb_t    stb,
  input  logic [W-1:0] x,
  output logic [W-1:0] z
);

  logic [W-1:0] a_q, b_q, c_q, z_q;
  logic [W-1:0] c_rev;

  xfer_bitrev #(.W(W)) u_rev (
    .din  (c_q),
    .dout (c_rev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      z_q <= '0;
    end else begin
      if (stb.ld_a)  a_q <= x;
      if (stb.inv_c) c_q <= ~a_q;
      if (stb.rev_b) b_q <= c_rev;
      if (stb.or_c)  c_q <= a_q | b_q;
      if (stb.out_z) z_q <= c_q;
    end
  end

  assign z = z_q;

endmodule

// File: rtl/seq_xfer_mover.sv
module seq_xfer_mover
  import xfer_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x,
  output logic [W-1:0] z,
  output logic         busy,
  output logic         done
);

  xfer_stb_t        stb;
  logic [STB_W-1:0] stb_bits;

  xfer_sequencer u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .stb   (stb),
    .busy  (busy),
    .done  (done)
  );

  xfer_datapath #(.W(W)) u_dp (
    .clk (clk),
    .rst (rst),
    .stb (stb),
    .x   (x),
    .z   (z)
  );

  assign stb_bits = stb;

endmodule

// File: rtl/xfer_mover_chk.sv
module xfer_mover_chk #(
  parameter int unsigned W = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] z,
  input logic [4:0]   stb
);

  // stb bit order: 0 load, 1 complement, 2 reverse, 3 merge, 4 output

  // R3: one transfer at a time
  p_one_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  // R3: each transfer follows the previous one by two cycles
  p_inv_after_load_r3: assert property (@(posedge clk) disable iff (rst)
    stb[1] |-> $past(stb[0], 2));
  p_rev_after_inv_r3: assert property (@(posedge clk) disable iff (rst)
    stb[2] |-> $past(stb[1], 2));
  p_or_after_rev_r3: assert property (@(posedge clk) disable iff (rst)
    stb[3] |-> $past(stb[2], 2));
  p_out_after_or_r3: assert property (@(posedge clk) disable iff (rst)
    stb[4] |-> $past(stb[3], 2));

  // R5: a run begins only from a start request
  p_busy_needs_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R5: a run keeps going until its output transfer
  p_no_early_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !stb[4]) |=> busy);

  // R6: z changes only when a completion is reported
  p_z_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(z));

  // R7: done is a one-cycle pulse that coincides with busy falling
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the cycle after a reset is idle and cleared
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && z == '0));

endmodule

bind seq_xfer_mover xfer_mover_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .z     (z),
  .stb   (stb_bits)
);

// File: tb/sim_seq_xfer_mover.sv
`timescale 1ns/1ps
module sim_seq_xfer_mover;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start2 = 1'b0, start4 = 1'b0;
  logic [1:0] x2 = '0, z2;
  logic [3:0] x4 = '0, z4;
  logic       busy2, done2, busy4, done4;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  seq_xfer_mover #(.W(2)) u0 (
    .clk(clk), .rst(rst), .start(start2), .x(x2),
    .z(z2), .busy(busy2), .done(done2)
  );

  seq_xfer_mover #(.W(4)) u1 (
    .clk(clk), .rst(rst), .start(start4), .x(x4),
    .z(z4), .busy(busy4), .done(done4)
  );

  function automatic logic [3:0] ref_out(input logic [3:0] v, input int w);
    logic [3:0] n, r;
    n = ~v;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = n[w-1-i];
    ref_out = (v | r) & 4'((1 << w) - 1);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Run on the 2-bit unit, optionally with a second start and new x at cycle 4.
  task automatic run2(input logic [1:0] v, input bit disturb, input string tag);
    logic [1:0] exp;
    exp = ref_out({2'b00, v}, 2);
    @(negedge clk); x2 = v; start2 = 1'b1;
    @(negedge clk); start2 = 1'b0;
    chk(busy2 == 1'b1, {tag, " R7 busy after accept"}, busy2, 1);
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      if (disturb && k == 4) begin
        start2 = 1'b1; x2 = ~v;
      end else begin
        start2 = 1'b0;
      end
      if (k == 9) chk(done2 == 1'b0 && busy2 == 1'b1, {tag, " R4 not early"}, done2, 0);
    end
    @(negedge clk);
    chk(done2 == 1'b1, {tag, " R4 done at cycle 10"}, done2, 1);
    chk(busy2 == 1'b0, {tag, " R7 busy falls with done"}, busy2, 0);
    chk(z2 == exp, {tag, " R1 result"}, z2, exp);
    @(negedge clk);
    chk(done2 == 1'b0, {tag, " R7 done one cycle"}, done2, 0);
  endtask

  task automatic run4(input logic [3:0] v);
    logic [3:0] exp;
    exp = ref_out(v, 4);
    @(negedge clk); x4 = v; start4 = 1'b1;
    @(negedge clk); start4 = 1'b0;
    for (int k = 1; k < 10; k++) @(negedge clk);
    chk(done4 == 1'b0, "R4 w4 not early", done4, 0);
    @(negedge clk);
    chk(done4 == 1'b1, "R4 w4 done at cycle 10", done4, 1);
    chk(z4 == exp, "R2 w4 result", z4, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(z2 == 0 && busy2 == 0 && done2 == 0, "R8 reset state w2", z2, 0);
    chk(z4 == 0 && busy4 == 0 && done4 == 0, "R8 reset state w4", z4, 0);

    // R1: full sweep at 2 bits
    for (int v = 0; v < 4; v++) run2(2'(v), 1'b0, "sweep");
    // R2: full sweep at 4 bits
    for (int v = 0; v < 16; v++) run4(4'(v));

    // R5, R9: start and x change mid-run are ignored
    run2(2'b01, 1'b1, "midrun");
    begin
      bit extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done2 || busy2) extra = 1;
      end
      chk(extra == 0, "R5 no second run", extra, 0);
    end

    // R6: z holds while idle with x toggling
    begin
      logic [1:0] held;
      held = z2;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk); x2 = 2'(k);
      end
      chk(z2 == held && done2 == 0, "R6 z holds while idle", z2, held);
    end

    // R8: reset in mid-run
    @(negedge clk); x2 = 2'b10; start2 = 1'b1;
    @(negedge clk); start2 = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(z2 == 0 && busy2 == 0 && done2 == 0, "R8 mid-run reset clears", z2, 0);
    begin
      bit seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done2) seen = 1;
      end
      chk(seen == 0, "R8 no done after reset", seen, 0);
    end

    // R3/R4: back-to-back run straight after reset recovery
    run2(2'b00, 1'b0, "after_reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule